// File: doc/BRIEF.md
# Multi-Codec Serial Audio Link Controller

This block is the controller end of a synchronous serial audio link. It runs on a bit clock that comes in from outside. It cuts that clock into frames of `FRAME_BITS` bit periods and marks the start of each frame with a frame-sync pulse. On one serial output that all attached codecs share, it sends a parallel-loaded outbound word, most significant bit first. In the same frames it collects the bits arriving on up to `NUM_LANES` dedicated serial inputs, one input per codec. Each codec is selected by a two-bit position: 0 is the primary and 1 to 3 are the secondaries. Because every position has its own input lane, the inputs never contend. The sync line, the serial output and the active-low codec reset line are shared by all codecs.

All outbound signals change on the rising edge of the bit clock. Every inbound bit is sampled on the falling edge that follows the rising edge on which it was launched. A small state machine orders the link:
- `ST_HOLD`: the codec reset line is asserted.
- `ST_ARM`: reset is released and the link is idle for one bit period.
- `ST_RUN`: frames are running.

The transitions are:
- hold-done: `ST_HOLD` to `ST_ARM`, after `RST_CYCLES` periods with no reset request.
- launch: `ST_ARM` to `ST_RUN`, which sends bit 0 of the first frame.
- wrap: `ST_RUN` to `ST_RUN` at the last bit, which starts the next frame.
- abort: `ST_ARM` or `ST_RUN` to `ST_HOLD`, on a cold-reset request.

At the last bit of every frame, each enabled lane presents its captured word together with a one-period valid pulse.

Top module: `slink_ctrl`

## Requirements
- R1: While running without interruption, successive rising edges of `link_sync` are exactly `FRAME_BITS` (256) bit periods apart.
- R2: `link_sync` goes high in the period that carries bit 0 of a frame and stays high for exactly `TAG_BITS` (16) periods. It stays low for the rest of the frame.
- R3: `link_sync` and `link_sdo` change only on rising edges of `bit_clk`. In frame period i (0..255), `link_sdo` carries bit `255-i` of the latched outbound word, so the word goes out MSB first.
- R4: The outbound word is taken from `tx_frame` at the rising edge that starts bit 0. `tx_frame_take` is high during exactly that bit-0 period. A change on `tx_frame` at any other time has no effect on the frame in flight.
- R5: Each `link_sdi` bit is sampled on the falling edge that follows its launching rising edge. After the falling edge of bit 255, an enabled lane's word carries bit 0 of the frame in its MSB. Its `rx_valid` bit is high for exactly one period, from that falling edge to the next one.
- R6: `lane_en` bit l gates lane l, which is fed by `link_sdi[l]` and reported on `rx_frame[l*256 +: 256]` and `rx_valid[l]`. The mask value present at the falling edge of bit 255 decides that frame's delivery. A lane disabled at that edge gives no valid pulse and keeps its previous word.
- R7: While `rst_n` is low, `link_rst_n`, `link_sync`, `link_sdo`, `tx_frame_take` and `rx_valid` are all 0, and every `rx_frame` word is 0.
- R8: After `rst_n` is released, `link_rst_n` stays low for `RST_CYCLES` (4) rising edges and then goes high. One idle period with sync low follows, and then bit 0 of the first frame.
- R9: A `cold_rst_req` seen high at a rising edge aborts the frame in flight. From that edge on, `link_rst_n`, `link_sync` and `link_sdo` are low. The aborted frame delivers no valid pulse. The R8 sequence restarts `RST_CYCLES` edges after the request drops.
- R10: The lanes are independent. Each lane's word holds only the bits from its own `link_sdi` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| cold_rst_req | input | 1 | Request to assert the shared codec reset and abort framing |
| lane_en | input | NUM_LANES | Per-lane capture enable mask |
| tx_frame | input | FRAME_BITS | Parallel outbound frame word |
| tx_frame_take | output | 1 | High during bit 0; marks that `tx_frame` was just latched |
| link_sync | output | 1 | Frame sync to the codecs |
| link_sdo | output | 1 | Shared serial data to the codecs |
| link_rst_n | output | 1 | Shared active-low codec reset |
| link_sdi | input | NUM_LANES | Serial data from each codec, one bit per lane |
| rx_frame | output | NUM_LANES*FRAME_BITS | Captured frame words, lane l at bits l*FRAME_BITS upward |
| rx_valid | output | NUM_LANES | One-period pulse per lane when its word is updated |

## Verification
Several properties are checked on every clock edge:
- Sync rises only on bit 0.
- Sync falls after the tag phase.
- The frame wraps at the last bit.
- The load strobe coincides with a sync rise.
- The link stays quiet while the codec reset is asserted, and a reset request aborts framing.
- The valid pulses last one period, follow the last bit, and respect the mask.

The bench scenarios cover what no property can express. These are the MSB-first content of the outbound serial stream against a frozen word, the content of each captured word per lane, and the exact length of the reset hold. They also cover mid-frame and boundary reset aborts and a mask that changes every period.

// File: rtl/slink_pkg.sv
`timescale 1ns/1ps
package slink_pkg;

    // Link sequencing states
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,   // codec reset asserted
        ST_ARM  = 2'd1,   // reset released, one idle bit period
        ST_RUN  = 2'd2    // frames running
    } link_state_e;

endpackage

// File: rtl/slink_tx_framer.sv
`timescale 1ns/1ps
module slink_tx_framer
    import slink_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic                          bit_clk,
    input  logic                          rst_n,
    input  logic                          cold_rst_req,
    input  logic [FRAME_BITS-1:0]         tx_frame,
    output logic                          tx_frame_take,
    output logic                          link_sync,
    output logic                          link_sdo,
    output logic                          link_rst_n,
    output logic                          live,
    output logic                          last_bit,
    output logic [$clog2(FRAME_BITS)-1:0] frame_pos
);

    localparam int CNT_W  = $clog2(FRAME_BITS);
    localparam int HOLD_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  LAST_POS = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0]  TAG_LAST = CNT_W'(TAG_BITS - 1);
    localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(RST_CYCLES - 1);

    link_state_e             state_q;
    link_state_e             state_d;
    logic [HOLD_W-1:0]       hold_q;
    logic [CNT_W-1:0]        bit_cnt;
    logic [FRAME_BITS-1:0]   out_sh;
    logic                    hold_done;
    logic                    at_wrap;

    assign hold_done = (hold_q == HOLD_END);
    assign at_wrap   = (bit_cnt == LAST_POS);

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: hold-done, launch, wrap, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!cold_rst_req && hold_done) state_d = ST_ARM;
            ST_ARM:  state_d = cold_rst_req ? ST_HOLD : ST_RUN;
            ST_RUN:  state_d = cold_rst_req ? ST_HOLD : ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs and datapath, all launched on the rising edge
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q        <= '0;
            bit_cnt       <= '0;
            out_sh        <= '0;
            link_sync     <= 1'b0;
            link_sdo      <= 1'b0;
            tx_frame_take <= 1'b0;
            link_rst_n    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    link_sync     <= 1'b0;
                    link_sdo      <= 1'b0;
                    tx_frame_take <= 1'b0;
                    bit_cnt       <= '0;
                    if (cold_rst_req) begin
                        hold_q <= '0;
                    end else if (hold_done) begin
                        hold_q     <= '0;
                        link_rst_n <= 1'b1;
                    end else begin
                        hold_q <= hold_q + 1'b1;
                    end
                end
                ST_ARM, ST_RUN: begin
                    if (cold_rst_req) begin
                        link_rst_n    <= 1'b0;
                        link_sync     <= 1'b0;
                        link_sdo      <= 1'b0;
                        tx_frame_take <= 1'b0;
                        bit_cnt       <= '0;
                        hold_q        <= '0;
                    end else if (state_q == ST_ARM || at_wrap) begin
                        bit_cnt       <= '0;
                        link_sync     <= 1'b1;
                        link_sdo      <= tx_frame[FRAME_BITS-1];
                        out_sh        <= {tx_frame[FRAME_BITS-2:0], 1'b0};
                        tx_frame_take <= 1'b1;
                    end else begin
                        bit_cnt       <= bit_cnt + 1'b1;
                        link_sync     <= link_sync && (bit_cnt != TAG_LAST);
                        link_sdo      <= out_sh[FRAME_BITS-1];
                        out_sh        <= {out_sh[FRAME_BITS-2:0], 1'b0};
                        tx_frame_take <= 1'b0;
                    end
                end
                default: begin
                    link_rst_n <= 1'b0;
                    link_sync  <= 1'b0;
                    link_sdo   <= 1'b0;
                end
            endcase
        end
    end

    assign live      = (state_q == ST_RUN);
    assign last_bit  = live && at_wrap;
    assign frame_pos = bit_cnt;

endmodule

// File: rtl/slink_rx_lane.sv
`timescale 1ns/1ps
module slink_rx_lane #(
    parameter int FRAME_BITS = 256
) (
    input  logic                  bit_clk,
    input  logic                  rst_n,
    input  logic                  live,
    input  logic                  last_bit,
    input  logic                  lane_on,
    input  logic                  sdi,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_valid
);

    logic [FRAME_BITS-1:0] in_sh;
    logic [FRAME_BITS-1:0] in_next;

    assign in_next = {in_sh[FRAME_BITS-2:0], sdi};

    // Capture on the falling edge after each launching rising edge
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sh    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (live) begin
                in_sh <= in_next;
                if (last_bit && lane_on) begin
                    rx_word  <= in_next;
                    rx_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/slink_ctrl.sv
`timescale 1ns/1ps
module slink_ctrl #(
    parameter int NUM_LANES  = 4,
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16,
    parameter int RST_CYCLES = 4
) (
    input  logic                            bit_clk,
    input  logic                            rst_n,
    input  logic                            cold_rst_req,
    input  logic [NUM_LANES-1:0]            lane_en,
    input  logic [FRAME_BITS-1:0]           tx_frame,
    output logic                            tx_frame_take,
    output logic                            link_sync,
    output logic                            link_sdo,
    output logic                            link_rst_n,
    input  logic [NUM_LANES-1:0]            link_sdi,
    output logic [NUM_LANES*FRAME_BITS-1:0] rx_frame,
    output logic [NUM_LANES-1:0]            rx_valid
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    logic             live;
    logic             last_bit;
    logic [CNT_W-1:0] frame_pos;

    slink_tx_framer #(
        .FRAME_BITS (FRAME_BITS),
        .TAG_BITS   (TAG_BITS),
        .RST_CYCLES (RST_CYCLES)
    ) u_tx (
        .bit_clk       (bit_clk),
        .rst_n         (rst_n),
        .cold_rst_req  (cold_rst_req),
        .tx_frame      (tx_frame),
        .tx_frame_take (tx_frame_take),
        .link_sync     (link_sync),
        .link_sdo      (link_sdo),
        .link_rst_n    (link_rst_n),
        .live          (live),
        .last_bit      (last_bit),
        .frame_pos     (frame_pos)
    );

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        slink_rx_lane #(
            .FRAME_BITS (FRAME_BITS)
        ) u_lane (
            .bit_clk  (bit_clk),
            .rst_n    (rst_n),
            .live     (live),
            .last_bit (last_bit),
            .lane_on  (lane_en[l]),
            .sdi      (link_sdi[l]),
            .rx_word  (rx_frame[l*FRAME_BITS +: FRAME_BITS]),
            .rx_valid (rx_valid[l])
        );
    end

endmodule

// File: rtl/slink_ctrl_chk.sv
`timescale 1ns/1ps
module slink_ctrl_chk #(
    parameter int NUM_LANES  = 4,
    parameter int FRAME_BITS = 256,
    parameter int TAG_BITS   = 16
) (
    input logic                          bit_clk,
    input logic                          rst_n,
    input logic                          cold_rst_req,
    input logic [NUM_LANES-1:0]          lane_en,
    input logic                          tx_frame_take,
    input logic                          link_sync,
    input logic                          link_sdo,
    input logic                          link_rst_n,
    input logic [NUM_LANES-1:0]          rx_valid,
    input logic                          live,
    input logic                          last_bit,
    input logic [$clog2(FRAME_BITS)-1:0] frame_pos
);

    localparam int CNT_W = $clog2(FRAME_BITS);

    AST_QUIET_IN_RESET: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !link_rst_n |-> (!link_sync && !link_sdo)); // R9

    AST_SYNC_AT_BIT0: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(link_sync) |-> (live && frame_pos == '0)); // R2

    AST_SYNC_TAG_END: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (live && frame_pos == CNT_W'(TAG_BITS - 1) && !cold_rst_req) |=> !link_sync); // R2

    AST_FRAME_WRAP: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (live && frame_pos == CNT_W'(FRAME_BITS - 1) && !cold_rst_req) |=> (link_sync && frame_pos == '0)); // R1

    AST_TAKE_WITH_SYNC: assert property (@(posedge bit_clk) disable iff (!rst_n)
        tx_frame_take |-> $rose(link_sync)); // R4

    AST_COLD_ABORT: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cold_rst_req |=> (!link_rst_n && !link_sync && !live)); // R9

    AST_ARM_IDLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(link_rst_n) |-> !link_sync); // R8

    AST_VALID_ONE_PERIOD: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (|rx_valid) |=> (rx_valid == '0)); // R5

    AST_VALID_AFTER_LAST: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (|rx_valid) |-> $past(last_bit)); // R5

    AST_VALID_MASKED: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (rx_valid & ~$past(lane_en)) == '0); // R6

endmodule

bind slink_ctrl slink_ctrl_chk #(
    .NUM_LANES  (NUM_LANES),
    .FRAME_BITS (FRAME_BITS),
    .TAG_BITS   (TAG_BITS)
) u_chk (
    .bit_clk       (bit_clk),
    .rst_n         (rst_n),
    .cold_rst_req  (cold_rst_req),
    .lane_en       (lane_en),
    .tx_frame_take (tx_frame_take),
    .link_sync     (link_sync),
    .link_sdo      (link_sdo),
    .link_rst_n    (link_rst_n),
    .rx_valid      (rx_valid),
    .live          (live),
    .last_bit      (last_bit),
    .frame_pos     (frame_pos)
);

// File: tb/test_slink_ctrl.sv
`timescale 1ns/1ps
module test_slink_ctrl;

    localparam int NL = 4;
    localparam int FB = 256;
    localparam int TB = 16;
    localparam int RC = 4;

    logic                bit_clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cold_rst_req = 1'b0;
    logic [NL-1:0]       lane_en = '0;
    logic [FB-1:0]       tx_frame = '0;
    logic                tx_frame_take;
    logic                link_sync;
    logic                link_sdo;
    logic                link_rst_n;
    logic [NL-1:0]       link_sdi = '0;
    logic [NL*FB-1:0]    rx_frame;
    logic [NL-1:0]       rx_valid;

    always #2 bit_clk = ~bit_clk;

    slink_ctrl #(
        .NUM_LANES (NL), .FRAME_BITS (FB), .TAG_BITS (TB), .RST_CYCLES (RC)
    ) i_slink_ctrl (
        .bit_clk (bit_clk), .rst_n (rst_n), .cold_rst_req (cold_rst_req),
        .lane_en (lane_en), .tx_frame (tx_frame), .tx_frame_take (tx_frame_take),
        .link_sync (link_sync), .link_sdo (link_sdo), .link_rst_n (link_rst_n),
        .link_sdi (link_sdi), .rx_frame (rx_frame), .rx_valid (rx_valid)
    );

    int n_vec = 0;
    int n_bad = 0;

    // Expected-value model
    int            mstate = 0;   // 0 hold, 1 arm, 2 run
    int            mhold  = 0;
    int            mcnt   = 0;
    int            cyc    = 0;
    int            last_rise = -1;
    int            nfr = 0;
    logic          prev_sync = 1'b0;
    logic          cold_phase = 1'b0;
    logic [FB-1:0] mframe = '0;
    logic          e_rst = 0, e_sync = 0, e_sdo = 0, e_take = 0;
    logic [FB-1:0] word   [NL];
    logic [FB-1:0] exp_rx [NL];

    function automatic logic [FB-1:0] rand_word();
        logic [FB-1:0] r = '0;
        for (int k = 0; k < FB / 32; k++) r = {r[FB-33:0], $urandom()};
        return r;
    endfunction

    function automatic logic [FB-1:0] next_tx(input int k);
        case (k)
            0:       return '1;
            1:       return '0;
            2:       return {(FB/2){2'b10}};
            default: return rand_word();
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [FB-1:0] act, input logic [FB-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mstate = 0; mhold = 0; mcnt = 0;
        e_rst = 0; e_sync = 0; e_sdo = 0; e_take = 0;
        last_rise = -1; prev_sync = 0;
        for (int l = 0; l < NL; l++) exp_rx[l] = '0;
    endtask

    // Hold rst_n low for a few periods, checking the reset state (R7)
    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (3) begin
            @(posedge bit_clk); #1;
            chk("R7", "link_rst_n", FB'(link_rst_n), '0);
            chk("R7", "sync", FB'(link_sync), '0);
            chk("R7", "sdo", FB'(link_sdo), '0);
            chk("R7", "take", FB'(tx_frame_take), '0);
            #2;
            chk("R7", "rx_valid", FB'(rx_valid), '0);
            for (int l = 0; l < NL; l++)
                chk("R7", "rx_frame", rx_frame[l*FB +: FB], '0);
        end
        rst_n = 1'b1;
    endtask

    // One bit period: edge model, tx checks at +1, rx checks at +3
    task automatic step();
        logic req;
        @(posedge bit_clk);
        req = cold_rst_req;
        cyc++;
        if (mstate == 0) begin
            e_sync = 0; e_sdo = 0; e_take = 0;
            if (req) mhold = 0;
            else if (mhold == RC - 1) begin mhold = 0; e_rst = 1; mstate = 1; end
            else mhold++;
        end else if (req) begin
            mstate = 0; mhold = 0; e_rst = 0; e_sync = 0; e_sdo = 0; e_take = 0;
            last_rise = -1;
        end else if (mstate == 1 || mcnt == FB - 1) begin
            mframe = tx_frame; mcnt = 0; mstate = 2;
            e_take = 1; e_sync = 1; e_sdo = mframe[FB-1];
        end else begin
            mcnt++; e_take = 0;
            e_sync = (mcnt < TB);
            e_sdo  = mframe[FB-1-mcnt];
        end
        #1;
        chk(cold_phase ? "R9" : "R8", "link_rst_n", FB'(link_rst_n), FB'(e_rst));
        chk("R2", "sync", FB'(link_sync), FB'(e_sync));
        chk("R3", "sdo", FB'(link_sdo), FB'(e_sdo));
        chk("R4", "take", FB'(tx_frame_take), FB'(e_take));
        if (link_sync && !prev_sync) begin
            if (last_rise >= 0) chk("R1", "frame period", FB'(cyc - last_rise), FB'(FB));
            last_rise = cyc;
        end
        prev_sync = link_sync;
        if (tx_frame_take) begin
            tx_frame = next_tx(nfr);
            nfr++;
        end else if (mstate == 2 && mcnt == 100) begin
            tx_frame = rand_word();   // mid-frame change must not matter (R4)
        end
        for (int l = 0; l < NL; l++)
            link_sdi[l] = (mstate == 2) ? word[l][FB-1-mcnt] : 1'($urandom());
        #2;
        chk("R3", "sync held at fall", FB'(link_sync), FB'(e_sync));
        chk("R3", "sdo held at fall", FB'(link_sdo), FB'(e_sdo));
        if (mstate == 2 && mcnt == FB - 1) begin
            chk("R5", "rx_valid", FB'(rx_valid), FB'(lane_en));
            for (int l = 0; l < NL; l++) begin
                if (lane_en[l]) exp_rx[l] = word[l];
                word[l] = rand_word();
            end
        end else begin
            chk(cold_phase ? "R9" : "R5", "rx_valid idle", FB'(rx_valid), '0);
        end
        for (int l = 0; l < NL; l++)
            chk(lane_en[l] ? "R10" : "R6", "rx_frame", rx_frame[l*FB +: FB], exp_rx[l]);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic run_to_pos(input int pos);
        step();
        while (!(mstate == 2 && mcnt == pos)) step();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int l = 0; l < NL; l++) begin
            word[l] = rand_word();
            exp_rx[l] = '0;
        end
        tx_frame = next_tx(nfr); nfr++;
        #1;
        do_reset();
        lane_en = 4'hF;
        run(3 * FB + 20);
        // partial mask
        lane_en = 4'b0101;
        run(2 * FB);
        // mid-frame cold reset held for several periods (R9)
        lane_en = 4'hF;
        run_to_pos(100);
        cold_phase = 1'b1;
        cold_rst_req = 1'b1;
        run(5);
        cold_rst_req = 1'b0;
        run(RC + 3);
        cold_phase = 1'b0;
        run(2 * FB);
        // mask changing every period (R6)
        for (int i = 0; i < FB; i++) begin
            lane_en = 4'($urandom());
            step();
        end
        lane_en = '0;
        run(FB + 10);
        // one-period cold reset right at the frame boundary (R9)
        lane_en = 4'b1010;
        run_to_pos(FB - 1);
        cold_phase = 1'b1;
        cold_rst_req = 1'b1;
        step();
        cold_rst_req = 1'b0;
        run(RC + 3);
        cold_phase = 1'b0;
        run(2 * FB);
        // asynchronous controller reset mid-run (R7, R8)
        run_to_pos(50);
        do_reset();
        lane_en = 4'hF;
        run(2 * FB + 20);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule